// File: doc/BRIEF.md
# Bitmap VGA Scanout with Time-Sliced Framebuffer Port

This block drives a 640x480 monochrome VGA monitor from a framebuffer held in asynchronous SRAM built from byte-wide chips. It runs on the 25 MHz pixel clock and emits one 1-bit pixel per clock. Because one SRAM word holds as many pixels as the word has bits, each line is split into fixed video cycles of `WORD_W` clocks, numbered phase 0 to phase `WORD_W-1`. The last four phases of every cycle belong to the display fetch. The earlier phases are free for writes coming from a slow host.

The host presents one write at a time: a one-clock strobe with a word address, data and byte enables, already synchronous to the pixel clock. A single holding entry captures it. The entry is written to SRAM in the next legal slot, so a strobe that lands in the fetch window is delayed but never lost. The host must space its strobes by more than one video cycle.

Top module: `vga_fb_scanout`

## Requirements
- R1: A line is H_VIS+H_FP+H_SYNC+H_BP clocks long. A frame is V_VIS+V_FP+V_SYNC+V_BP lines long. `vga_de_o` is high for the first H_VIS clocks of each of the first V_VIS lines. `vga_hsync_n_o` is low for H_SYNC clocks, starting H_VIS+H_FP clocks into the line. `vga_vsync_n_o` is low for V_SYNC lines, starting V_VIS+V_FP lines into the frame. All video outputs are registered and lag the internal raster position by one clock.
- R2: A synchronous high reset sets all outputs idle: both syncs high, de and pix low, `sram_oe_n_o` high, every `sram_we_n_o` bit high, `sram_dq_oe_o` low. The raster then resumes at pixel 0 of the last line of the frame.
- R3: Video cycles are aligned to line start (the line length is a multiple of WORD_W). `sram_oe_n_o` is low in exactly the last four phases of every cycle. The address stays unchanged while it is low.
- R4: During the fetch that precedes a visible cycle, the address is line*(H_VIS/WORD_W) + column/WORD_W of that cycle. The count restarts from word 0 every frame.
- R5: The word on `sram_dq_i` at the end of the last phase is shown in the next cycle, bit WORD_W-1 first. `vga_pix_o` is 0 whenever de is 0.
- R6: A strobe sampled in phase p, with p at most WORD_W-8, produces its SRAM write pulse in phase p+2 of the same cycle.
- R7: A strobe sampled in phase p, with p at least WORD_W-7 (including the fetch window), produces its write pulse in phase 1 of the next cycle.
- R8: A write pulse lasts one clock. During the pulse, the held address and data are driven and `sram_dq_oe_o` is high. Data stays driven, with no pulse, for one more clock. A pulse never overlaps `sram_oe_n_o` low. Bit b of `sram_we_n_o` pulses only if `host_be_i[b]` was set; bit 0 covers data[7:0] and bit 1 covers data[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_i | input | 1 | One-clock host write strobe |
| host_addr_i | input | AW | Host word address |
| host_data_i | input | WORD_W | Host write data |
| host_be_i | input | LANES | Host byte enables |
| sram_addr_o | output | AW | SRAM word address |
| sram_dq_o | output | WORD_W | SRAM write data |
| sram_dq_oe_o | output | 1 | Drive enable for the SRAM data bus |
| sram_dq_i | input | WORD_W | SRAM read data |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | LANES | Per-chip write enable, active low |
| vga_hsync_n_o | output | 1 | Horizontal sync, active low |
| vga_vsync_n_o | output | 1 | Vertical sync, active low |
| vga_de_o | output | 1 | Visible-area flag |
| vga_pix_o | output | 1 | Pixel value |

## Verification
The framebuffer model is filled with random words, so scanned pixels tell MSB-first order apart from reversed order. They also show an address off by one word or one line, and a word shown one cycle early or late. Directed host strobes at phases 0, 8, 9, 11, 12 and 15 pin the edge between the same-cycle and the deferred slot. They also check that no strobe is dropped inside the fetch window. Random strobes with random partial byte enables then separate correct per-chip write pulses from whole-word writes. Running several frames with writes landing in visible words shows the per-frame restart of the fetch address.

// File: rtl/vga_fb_pkg.sv
package vga_fb_pkg;
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_STROBE = 2'd1,
    WR_HOLD   = 2'd2
  } wr_state_t;

  localparam int FETCH_PHASES = 4;
endpackage

// File: rtl/vga_raster_timing.sv
module vga_raster_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int PHASES = 16,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT),
  localparam int PW    = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          cur_vis,
  output logic          nxt_vis,
  output logic          line_blank,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de
);
  localparam int HS_ON  = H_VIS + H_FP;
  localparam int HS_OFF = HS_ON + H_SYNC;
  localparam int VS_ON  = V_VIS + V_FP;
  localparam int VS_OFF = VS_ON + V_SYNC;

  logic [HW-1:0] hcnt, hcnt_nx;
  logic [VW-1:0] vcnt, vcnt_nx;
  logic          h_last;

  assign h_last  = (hcnt == HW'(H_TOT - 1));
  assign hcnt_nx = h_last ? '0 : hcnt + 1'b1;
  assign vcnt_nx = !h_last ? vcnt : (vcnt == VW'(V_TOT - 1)) ? '0 : vcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= VW'(V_TOT - 1);
    end else begin
      hcnt <= hcnt_nx;
      vcnt <= vcnt_nx;
    end
  end

  assign phase      = hcnt[PW-1:0];
  assign cur_vis    = (hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS));
  assign nxt_vis    = (hcnt_nx < HW'(H_VIS)) && (vcnt_nx < VW'(V_VIS));
  assign line_blank = (vcnt >= VW'(V_VIS));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      de      <= 1'b0;
    end else begin
      hsync_n <= !((hcnt >= HW'(HS_ON)) && (hcnt < HW'(HS_OFF)));
      vsync_n <= !((vcnt >= VW'(VS_ON)) && (vcnt < VW'(VS_OFF)));
      de      <= cur_vis;
    end
  end
endmodule

// File: rtl/fb_write_hold.sv
module fb_write_hold #(
  parameter int AW     = 17,
  parameter int WORD_W = 16,
  parameter int LANES  = 2,
  localparam int LANE_W = WORD_W / LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_data,
  input  logic [LANES-1:0]  host_be,
  input  logic              take,
  output logic              pend,
  output logic [AW-1:0]     held_addr,
  output logic [WORD_W-1:0] held_data,
  output logic [LANES-1:0]  held_be
);
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (host_wr) pend <= 1'b1;
    else if (take)    pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          held_addr <= '0;
    else if (host_wr) held_addr <= host_addr;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        held_data[g*LANE_W +: LANE_W] <= '0;
        held_be[g]                    <= 1'b0;
      end else if (host_wr) begin
        held_data[g*LANE_W +: LANE_W] <= host_data[g*LANE_W +: LANE_W];
        held_be[g]                    <= host_be[g];
      end
    end
  end
endmodule

// File: rtl/fb_sram_port.sv
module fb_sram_port
  import vga_fb_pkg::*;
#(
  parameter int AW     = 17,
  parameter int WORD_W = 16,
  parameter int LANES  = 2,
  localparam int PHASES      = WORD_W,
  localparam int PW          = $clog2(PHASES),
  localparam int FETCH_FIRST = PHASES - FETCH_PHASES,
  localparam int LAST_START  = FETCH_FIRST - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     phase,
  input  logic              nxt_vis,
  input  logic              line_blank,
  input  logic              pend,
  input  logic [AW-1:0]     held_addr,
  input  logic [WORD_W-1:0] held_data,
  input  logic [LANES-1:0]  held_be,
  output logic              take,
  output logic [AW-1:0]     sram_addr,
  output logic [WORD_W-1:0] sram_dq,
  output logic              sram_dq_oe,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_we_n
);
  wr_state_t     st;
  logic [AW-1:0] fetch_addr;
  logic          last_phase;
  logic          pre_fetch;

  assign last_phase = (phase == PW'(PHASES - 1));
  assign pre_fetch  = (phase >= PW'(FETCH_FIRST - 1)) && (phase <= PW'(PHASES - 2));
  assign take       = pend && (st != WR_STROBE) && (phase <= PW'(LAST_START));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WR_IDLE;
      sram_addr  <= '0;
      sram_dq    <= '0;
      sram_dq_oe <= 1'b0;
      sram_we_n  <= '1;
      sram_oe_n  <= 1'b1;
    end else begin
      if (take) begin
        st         <= WR_STROBE;
        sram_addr  <= held_addr;
        sram_dq    <= held_data;
        sram_dq_oe <= 1'b1;
        sram_we_n  <= ~held_be;
      end else if (st == WR_STROBE) begin
        st        <= WR_HOLD;
        sram_we_n <= '1;
      end else if (st == WR_HOLD) begin
        st         <= WR_IDLE;
        sram_dq_oe <= 1'b0;
      end
      if (phase == PW'(FETCH_FIRST - 1)) sram_addr <= fetch_addr;
      sram_oe_n <= !pre_fetch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        fetch_addr <= '0;
    else if (last_phase && nxt_vis) fetch_addr <= fetch_addr + 1'b1;
    else if (line_blank)            fetch_addr <= '0;
  end
endmodule

// File: rtl/vga_pixel_shifter.sv
module vga_pixel_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              vis,
  input  logic [WORD_W-1:0] word_in,
  output logic              pix
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      pix <= 1'b0;
    end else begin
      pix <= vis & sr[WORD_W-1];
      if (load) sr <= word_in;
      else      sr <= {sr[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/vga_fb_scanout.sv
module vga_fb_scanout #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int AW     = 17,
  parameter int WORD_W = 16,
  parameter int LANES  = 2,
  localparam int PW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [WORD_W-1:0] host_data_i,
  input  logic [LANES-1:0]  host_be_i,
  output logic [AW-1:0]     sram_addr_o,
  output logic [WORD_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [WORD_W-1:0] sram_dq_i,
  output logic              sram_oe_n_o,
  output logic [LANES-1:0]  sram_we_n_o,
  output logic              vga_hsync_n_o,
  output logic              vga_vsync_n_o,
  output logic              vga_de_o,
  output logic              vga_pix_o
);
  logic [PW-1:0]     phase;
  logic              cur_vis, nxt_vis, line_blank;
  logic              pend, take;
  logic [AW-1:0]     held_addr;
  logic [WORD_W-1:0] held_data;
  logic [LANES-1:0]  held_be;

  vga_raster_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .PHASES(WORD_W)
  ) u_timing (
    .clk(clk), .rst(rst), .phase(phase), .cur_vis(cur_vis),
    .nxt_vis(nxt_vis), .line_blank(line_blank),
    .hsync_n(vga_hsync_n_o), .vsync_n(vga_vsync_n_o), .de(vga_de_o)
  );

  fb_write_hold #(.AW(AW), .WORD_W(WORD_W), .LANES(LANES)) u_hold (
    .clk(clk), .rst(rst), .host_wr(host_wr_i), .host_addr(host_addr_i),
    .host_data(host_data_i), .host_be(host_be_i), .take(take),
    .pend(pend), .held_addr(held_addr), .held_data(held_data), .held_be(held_be)
  );

  fb_sram_port #(.AW(AW), .WORD_W(WORD_W), .LANES(LANES)) u_port (
    .clk(clk), .rst(rst), .phase(phase), .nxt_vis(nxt_vis),
    .line_blank(line_blank), .pend(pend), .held_addr(held_addr),
    .held_data(held_data), .held_be(held_be), .take(take),
    .sram_addr(sram_addr_o), .sram_dq(sram_dq_o), .sram_dq_oe(sram_dq_oe_o),
    .sram_oe_n(sram_oe_n_o), .sram_we_n(sram_we_n_o)
  );

  vga_pixel_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(phase == PW'(WORD_W - 1)), .vis(cur_vis),
    .word_in(sram_dq_i), .pix(vga_pix_o)
  );
endmodule

// File: rtl/vga_fb_scanout_chk.sv
module vga_fb_scanout_chk #(
  parameter int AW    = 17,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync_n,
  input logic             de,
  input logic             pix,
  input logic             oe_n,
  input logic [LANES-1:0] we_n,
  input logic             dq_oe,
  input logic [AW-1:0]    addr
);
  localparam logic [LANES-1:0] IDLE_WE = '1;

  AST_READ_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n == IDLE_WE) && !dq_oe);                              // R8
  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (we_n != IDLE_WE) |=> (we_n == IDLE_WE) && dq_oe);                   // R8
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    (we_n != IDLE_WE) |-> dq_oe);                                        // R8
  AST_FETCH_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !$past(oe_n)) |-> $stable(addr));                          // R3
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    !de |-> !pix);                                                       // R5
  AST_SYNC_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !de);                                                   // R1
endmodule

bind vga_fb_scanout vga_fb_scanout_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .hsync_n(vga_hsync_n_o), .de(vga_de_o),
  .pix(vga_pix_o), .oe_n(sram_oe_n_o), .we_n(sram_we_n_o),
  .dq_oe(sram_dq_oe_o), .addr(sram_addr_o)
);

// File: tb/tb_vga_fb_scanout.sv
`timescale 1ns/100ps
module tb_vga_fb_scanout;
  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 4,  VF = 1, VS = 1, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int AW = 17, W = 16, L = 2;
  localparam int WPL = HV / W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [W-1:0]  host_data = '0;
  logic [L-1:0]  host_be = '0;
  logic [AW-1:0] sram_addr;
  logic [W-1:0]  sram_dq_o, sram_dq_i;
  logic          sram_dq_oe, sram_oe_n;
  logic [L-1:0]  sram_we_n;
  logic          hs_n, vs_n, de, pix;

  logic [W-1:0] mem [64];

  always #2.5 clk = ~clk;

  assign sram_dq_i = !sram_oe_n ? mem[sram_addr[5:0]] : '0;

  vga_fb_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .AW(AW), .WORD_W(W), .LANES(L)
  ) dut (
    .clk(clk), .rst(rst), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_data_i(host_data), .host_be_i(host_be), .sram_addr_o(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe), .sram_dq_i(sram_dq_i),
    .sram_oe_n_o(sram_oe_n), .sram_we_n_o(sram_we_n),
    .vga_hsync_n_o(hs_n), .vga_vsync_n_o(vs_n), .vga_de_o(de), .vga_pix_o(pix)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  int bh = 0, bv = VT - 1;
  bit exp_de, exp_hs, exp_vs, exp_pix;
  logic [W-1:0] cur_word = '0;

  bit           ew_valid = 1'b0;
  int           ew_cycle;
  bit           ew_late;
  logic [AW-1:0] ew_addr;
  logic [W-1:0]  ew_data;
  logic [L-1:0]  ew_be;
  bit           hold_due = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, expv);
    end
  endtask

  function automatic bit f_vis(input int h, input int v);
    return (h < HV) && (v < VV);
  endfunction

  always @(posedge clk) if (run) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (run && !done) begin
      int ph, nh, nv;
      ph = cyc % W;
      if (cyc == 0) begin
        chk(hs_n && vs_n && !de && !pix, "R2 video idle", {hs_n, vs_n, de, pix}, 4'b1100);
        chk(sram_oe_n && sram_we_n == 2'b11 && !sram_dq_oe, "R2 sram idle",
            {sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
      end else begin
        chk(de == exp_de, "R1 de", de, exp_de);
        chk(hs_n == exp_hs, "R1 hsync", hs_n, exp_hs);
        chk(vs_n == exp_vs, "R1 vsync", vs_n, exp_vs);
        chk(pix == exp_pix, "R5 pixel", pix, exp_pix);
      end
      chk(sram_oe_n == !(ph >= W - 4), "R3 oe window", sram_oe_n, !(ph >= W - 4));
      nh = bh + 4; nv = bv;
      if (nh >= HT) begin nh = 0; nv = (bv + 1) % VT; end
      if (ph == W - 4 && f_vis(nh, nv))
        chk(sram_addr == AW'(nv * WPL + nh / W), "R4 fetch address",
            sram_addr, nv * WPL + nh / W);
      // write pulse checks
      if (hold_due) begin
        chk(sram_dq_oe && sram_we_n == 2'b11, "R8 data hold", {sram_dq_oe, sram_we_n}, 3'b111);
        hold_due = 1'b0;
      end
      if (sram_we_n != 2'b11) begin
        chk(ew_valid && cyc == ew_cycle, ew_late ? "R7 write slot" : "R6 write slot",
            cyc, ew_cycle);
        chk(sram_addr == ew_addr, "R8 write address", sram_addr, ew_addr);
        chk(sram_we_n == ~ew_be, "R8 lane enables", sram_we_n, ~ew_be);
        for (int b = 0; b < L; b++)
          if (ew_be[b]) begin
            chk(sram_dq_o[b*8 +: 8] == ew_data[b*8 +: 8], "R8 write data",
                sram_dq_o[b*8 +: 8], ew_data[b*8 +: 8]);
            mem[sram_addr[5:0]][b*8 +: 8] = sram_dq_o[b*8 +: 8];
          end
        ew_valid = 1'b0;
        hold_due = 1'b1;
      end else if (ew_valid && cyc > ew_cycle) begin
        chk(1'b0, ew_late ? "R7 write missing" : "R6 write missing", cyc, ew_cycle);
        ew_valid = 1'b0;
      end
      // expectations for the next sample (outputs lag one clock)
      exp_de  = f_vis(bh, bv);
      exp_hs  = !((bh >= HV + HF) && (bh < HV + HF + HS));
      exp_vs  = !((bv >= VV + VF) && (bv < VV + VF + VS));
      exp_pix = exp_de ? cur_word[W - 1 - (bh % W)] : 1'b0;
      if (ph == W - 1) begin
        nh = bh + 1; nv = bv;
        if (nh >= HT) begin nh = 0; nv = (bv + 1) % VT; end
        cur_word = f_vis(nh, nv) ? mem[nv * WPL + nh / W] : '0;
      end
      bh = bh + 1;
      if (bh >= HT) begin bh = 0; bv = (bv + 1) % VT; end
    end
  end

  task automatic host_write(input int phase, input logic [AW-1:0] a,
                            input logic [W-1:0] d, input logic [L-1:0] be);
    int p;
    do begin @(posedge clk); #1; end while (cyc % W != phase);
    p = cyc % W;
    host_wr = 1'b1; host_addr = a; host_data = d; host_be = be;
    ew_addr = a; ew_data = d; ew_be = be;
    ew_late  = (p > W - 8);
    ew_cycle = cyc + ((p <= W - 8) ? 2 : (W + 1 - p));
    ew_valid = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
    repeat (24) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c3a));
    for (int i = 0; i < 64; i++) mem[i] = W'($urandom);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0; run = 1'b1;
    repeat (3 * HT) @(posedge clk);
    // directed: edges of the commit window and the fetch window
    host_write(0,  17'd1, 16'hA55A, 2'b11);
    host_write(8,  17'd2, 16'h0FF0, 2'b11);
    host_write(9,  17'd3, 16'hF00F, 2'b11);
    host_write(11, 17'd5, 16'h1234, 2'b01);
    host_write(12, 17'd6, 16'hABCD, 2'b10);
    host_write(15, 17'd7, 16'hFFFF, 2'b11);
    // random strobes
    for (int k = 0; k < 24; k++) begin
      logic [1:0] be;
      be = 2'($urandom_range(1, 3));
      host_write(int'($urandom_range(0, W - 1)), AW'($urandom_range(0, 31)),
                 W'($urandom), be);
    end
    repeat (3 * HT * VT) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule